// File: doc/BRIEF.md
# Byte-Parity Peripheral RAM with Parity Test Window

This block is a small single-port word memory for a peripheral. Each 32-bit word carries four parity bits, one per byte, and these bits are regenerated from the data on every data write. A four-bit key in the control register gates the parity check. The key value 0x5 turns checking off. Every other value, including the reset value 0xA, leaves checking on, so a control field that has been damaged still leaves the check enabled.

A test bit in the control register opens a window onto the parity bits. The window sits at a fixed word offset equal to the depth, directly above the data array. Software can read the bits there and overwrite them to plant an error. A damaged parity bit raises nothing by itself. The fault shows only when the affected data word is read. On that read the block pulses an error line toward the system error collector, sets a sticky status flag and latches the index of the failing word. Software undoes the damage by opening the window again and writing back the original parity.

All accesses use a simple request/acknowledge bus. A request is taken only in state IDLE. From there the machine moves to WR_ACK (IDLE→WR_ACK on a write) or RD_ACK (IDLE→RD_ACK on a read). It holds that state for exactly one cycle, with the acknowledge and any read data, and then returns (WR_ACK→IDLE, RD_ACK→IDLE).

Top module: `parity_ram`

## Requirements
- R1: After reset, bus_ack and par_err_pulse are 0. All data words read 0. The control register reads 0x0000000A, and the status flag and the failing-index register read 0.
- R2: A request is accepted in IDLE. bus_ack is high for exactly the one following cycle. Read data is valid in that cycle and equals the last word written to that index.
- R3: Every data write stores parity bit b of the word as the XOR of bits [8b+7:8b], which is even parity per byte. This also replaces any parity that was planted earlier.
- R4: Checking is disabled only when the control key (bits [3:0] of word address 32) equals 0x5. Every other key value enables it.
- R5: The parity of data word i is at word address 16+i, in bits [3:0]. It is readable and writable only while control bit 8 (test bit) is 1. Otherwise it reads 0 and writes to it are dropped.
- R6: Writing wrong parity produces no error. A later read of that data word with checking enabled returns the stored word and raises par_err_pulse for exactly one cycle, in the acknowledge cycle.
- R7: A detected mismatch sets status bit 0 (word address 48). The bit stays set until a write with bit 0 = 1 to that address. Writing 0 leaves it set.
- R8: The index of the most recent failing word is readable at word address 49. Software cannot change it.
- R9: Writing the original parity back through the test window removes the fault. A later read of that word raises no error.
- R10: The control register reads back the key in bits [3:0] and the test bit in bit 8.
- R11: A request that is still asserted during the acknowledge cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, taken in IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address: [5:4] region, [3:0] index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion strobe |
| par_err_pulse | output | 1 | One-cycle parity mismatch report |

## Verification
Several properties are checked on every cycle: the acknowledge is always a single-cycle strobe, the error pulse is one cycle long and comes only with a read acknowledge, and the pulse is always matched by a set status flag. The flag cannot drop without a clearing write, the failing index cannot move without a detection, and no detection is recorded while the key disables checking. Other behaviours are shown only by the bench scenarios. These include the per-byte parity values, the fact that planting a fault is silent until the word is read, the restore path, the full sweep of key values and the refusal of the test window while the test bit is clear.

// File: rtl/pram_pkg.sv
package pram_pkg;

    typedef enum logic [1:0] {
        RGN_DATA = 2'd0,
        RGN_PAR  = 2'd1,
        RGN_CTRL = 2'd2,
        RGN_STAT = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WR_ACK = 2'd1,
        ST_RD_ACK = 2'd2
    } state_e;

    localparam logic [3:0] KEY_OFF   = 4'h5;
    localparam logic [3:0] KEY_RESET = 4'hA;
    localparam int         TEST_BIT  = 8;

endpackage

// File: rtl/pram_store.sv
module pram_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int NB    = DW / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_data_en,
    input  logic             wr_par_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [NB-1:0]    wr_par,
    output logic [DW-1:0]    rd_word,
    output logic [NB-1:0]    rd_par
);

    logic [DW-1:0]              mem [DEPTH];
    logic [DEPTH-1:0][NB-1:0]   par;
    logic [NB-1:0]              gen_par;

    for (genvar b = 0; b < NB; b++) begin : g_par
        assign gen_par[b] = ^wr_data[b*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            par <= '0;
        end else if (wr_data_en) begin
            mem[wr_idx] <= wr_data;
            par[wr_idx] <= gen_par;
        end else if (wr_par_en) begin
            par[wr_idx] <= wr_par;
        end
    end

    assign rd_word = mem[rd_idx];
    assign rd_par  = par[rd_idx];

    // R5
    par_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_data_en && !wr_par_en) |=> $stable(par));

    // R3
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_data_en && wr_par_en));

endmodule

// File: rtl/pram_check.sv
module pram_check #(
    parameter int DW = 32,
    localparam int NB = DW / 8
) (
    input  logic [DW-1:0] word,
    input  logic [NB-1:0] par,
    output logic          mismatch
);

    logic [NB-1:0] diff;

    for (genvar b = 0; b < NB; b++) begin : g_cmp
        assign diff[b] = (^word[b*8 +: 8]) ^ par[b];
    end

    assign mismatch = |diff;

endmodule

// File: rtl/pram_regs.sv
module pram_regs #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             stat_we,
    input  logic [31:0]      wdata,
    input  logic             err_set,
    input  logic [IDX_W-1:0] err_idx,
    output logic [3:0]       key,
    output logic             test_en,
    output logic             chk_en,
    output logic             err_flag,
    output logic [IDX_W-1:0] fail_idx
);
    import pram_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key     <= KEY_RESET;
            test_en <= 1'b0;
        end else if (ctrl_we) begin
            key     <= wdata[3:0];
            test_en <= wdata[TEST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            fail_idx <= '0;
        end else begin
            if (err_set) begin
                err_flag <= 1'b1;
                fail_idx <= err_idx;
            end else if (stat_we && wdata[0]) begin
                err_flag <= 1'b0;
            end
        end
    end

    assign chk_en = (key != KEY_OFF);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !(stat_we && wdata[0])) |=> err_flag);

    // R8
    fail_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_set |=> $stable(fail_idx));

    // R4
    no_detect_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_set |-> (key != KEY_OFF));

endmodule

// File: rtl/parity_ram.sv
module parity_ram #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int NB    = DW / 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int AW    = IDX_W + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_ack,
    output logic          par_err_pulse
);
    import pram_pkg::*;

    state_e            state_q, state_d;
    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic              accept;
    logic              wr_data_en, wr_par_en, ctrl_we, stat_we, err_set;
    logic [DW-1:0]     rd_word;
    logic [NB-1:0]     rd_par;
    logic              mismatch;
    logic [3:0]        key;
    logic              test_en, chk_en, err_flag;
    logic [IDX_W-1:0]  fail_idx;
    logic [DW-1:0]     rd_mux;
    logic [DW-1:0]     rdata_q;
    logic              err_q;

    assign region = region_e'(bus_addr[AW-1 -: 2]);
    assign idx    = bus_addr[IDX_W-1:0];
    assign accept = (state_q == ST_IDLE) && bus_req;

    assign wr_data_en = accept && bus_we && (region == RGN_DATA);
    assign wr_par_en  = accept && bus_we && (region == RGN_PAR) && test_en;
    assign ctrl_we    = accept && bus_we && (region == RGN_CTRL) && (idx == '0);
    assign stat_we    = accept && bus_we && (region == RGN_STAT) && (idx == '0);
    assign err_set    = accept && !bus_we && (region == RGN_DATA) && chk_en && mismatch;

    pram_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (idx),
        .wr_data_en (wr_data_en),
        .wr_par_en  (wr_par_en),
        .wr_idx     (idx),
        .wr_data    (bus_wdata),
        .wr_par     (bus_wdata[NB-1:0]),
        .rd_word    (rd_word),
        .rd_par     (rd_par)
    );

    pram_check #(.DW(DW)) u_check (
        .word     (rd_word),
        .par      (rd_par),
        .mismatch (mismatch)
    );

    pram_regs #(.IDX_W(IDX_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_we  (ctrl_we),
        .stat_we  (stat_we),
        .wdata    (bus_wdata),
        .err_set  (err_set),
        .err_idx  (idx),
        .key      (key),
        .test_en  (test_en),
        .chk_en   (chk_en),
        .err_flag (err_flag),
        .fail_idx (fail_idx)
    );

    always_comb begin
        rd_mux = '0;
        unique case (region)
            RGN_DATA: rd_mux = rd_word;
            RGN_PAR:  if (test_en) rd_mux[NB-1:0] = rd_par;
            RGN_CTRL: if (idx == '0) begin
                rd_mux[3:0]      = key;
                rd_mux[TEST_BIT] = test_en;
            end
            RGN_STAT: begin
                if (idx == IDX_W'(0)) rd_mux[0] = err_flag;
                else if (idx == IDX_W'(1)) rd_mux[IDX_W-1:0] = fail_idx;
            end
            default: rd_mux = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:   if (bus_req) state_d = bus_we ? ST_WR_ACK : ST_RD_ACK;
            ST_WR_ACK: state_d = ST_IDLE;
            ST_RD_ACK: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= err_set;
            if (accept) rdata_q <= bus_we ? '0 : rd_mux;
        end
    end

    always_comb begin
        bus_ack       = (state_q != ST_IDLE);
        bus_rdata     = rdata_q;
        par_err_pulse = err_q;
    end

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_pulse |=> !par_err_pulse);

    // R6
    pulse_on_read_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_pulse |-> (bus_ack && state_q == ST_RD_ACK));

    // R7
    pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_err_pulse |-> err_flag);

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> (state_q == ST_IDLE));

endmodule

// File: tb/tb_parity_ram.sv
module tb_parity_ram;

    localparam int DEPTH = 16;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_ack;
    logic          par_err_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    parity_ram dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_ack       (bus_ack),
        .par_err_pulse (par_err_pulse)
    );

    localparam logic [AW-1:0] A_CTRL = 6'd32;
    localparam logic [AW-1:0] A_STAT = 6'd48;
    localparam logic [AW-1:0] A_FAIL = 6'd49;

    function automatic logic [31:0] pat(input int i);
        return (32'h1F35_9AC7 * (i + 3)) ^ (32'h0101_0101 << (i % 8));
    endfunction

    function automatic logic [3:0] epar(input logic [31:0] w);
        logic [3:0] p;
        for (int b = 0; b < 4; b++) begin
            p[b] = 1'b0;
            for (int k = 0; k < 8; k++) p[b] = p[b] ^ w[b*8+k];
        end
        return p;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] last_rd;
    logic        last_err;
    logic        last_ack;

    task automatic op(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
        last_rd  = bus_rdata;
        last_err = par_err_pulse;
        last_ack = bus_ack;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        op(1'b1, a, d);
    endtask

    task automatic rd(input logic [AW-1:0] a);
        op(1'b0, a, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ack after reset", {31'b0, bus_ack}, 32'h0);
        chk("R1 pulse after reset", {31'b0, par_err_pulse}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CTRL); chk("R1 R10 ctrl reset", last_rd, 32'h0000_000A);
        rd(A_STAT); chk("R1 status reset", last_rd, 32'h0);
        rd(A_FAIL); chk("R1 fail index reset", last_rd, 32'h0);
        rd(6'd5);   chk("R1 data reset", last_rd, 32'h0);
        chk("R1 no error on zero word", {31'b0, last_err}, 32'h0);

        // R2: fill and read back every word
        for (int i = 0; i < DEPTH; i++) begin
            wr(AW'(i), pat(i));
            chk("R2 write ack", {31'b0, last_ack}, 32'h1);
        end
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i));
            chk("R2 read data", last_rd, pat(i));
            chk("R2 read ack", {31'b0, last_ack}, 32'h1);
            chk("R2 no error on clean word", {31'b0, last_err}, 32'h0);
        end

        // R5: window closed
        rd(6'd17); chk("R5 closed window reads zero", last_rd, 32'h0);
        wr(6'd17, {28'h0, ~epar(pat(1))});
        rd(6'd1);  chk("R5 closed window write dropped", {31'b0, last_err}, 32'h0);

        // R10 / R3: open window, check all parity
        wr(A_CTRL, 32'h0000_010A);
        rd(A_CTRL); chk("R10 ctrl readback", last_rd, 32'h0000_010A);
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(DEPTH + i));
            chk("R3 R5 stored parity", last_rd, {28'h0, epar(pat(i))});
        end

        // R6 R7 R8 R9: plant, detect, restore per word
        for (int i = 0; i < DEPTH; i++) begin
            logic [3:0] good;
            good = epar(pat(i));
            wr(AW'(DEPTH + i), {28'h0, good ^ (4'b1 << (i % 4))});
            chk("R6 planting is silent", {31'b0, last_err}, 32'h0);
            rd(A_STAT); chk("R6 no flag before read", last_rd, 32'h0);
            rd(AW'(i));
            chk("R6 pulse on faulty read", {31'b0, last_err}, 32'h1);
            chk("R6 data returned", last_rd, pat(i));
            @(negedge clk);
            chk("R6 pulse one cycle", {31'b0, par_err_pulse}, 32'h0);
            rd(A_FAIL); chk("R8 fail index", last_rd, 32'(i));
            wr(A_FAIL, 32'h0);
            rd(A_FAIL); chk("R8 fail index read-only", last_rd, 32'(i));
            wr(AW'(DEPTH + i), {28'h0, good});
            rd(AW'(i)); chk("R9 restored word clean", {31'b0, last_err}, 32'h0);
            rd(A_STAT); chk("R7 flag sticky", last_rd, 32'h1);
            if (i == 0) begin
                wr(A_STAT, 32'h0);
                rd(A_STAT); chk("R7 write zero keeps flag", last_rd, 32'h1);
            end
            wr(A_STAT, 32'h1);
            rd(A_STAT); chk("R7 write one clears flag", last_rd, 32'h0);
        end

        // R4: every key value
        for (int k = 0; k < 16; k++) begin
            wr(A_CTRL, 32'h100 | 32'(k));
            wr(6'd19, {28'h0, ~epar(pat(3))});
            rd(6'd3);
            chk("R4 key gates detection", {31'b0, last_err}, (k == 5) ? 32'h0 : 32'h1);
            wr(6'd19, {28'h0, epar(pat(3))});
            wr(A_STAT, 32'h1);
        end

        // R3: data write replaces planted parity
        wr(A_CTRL, 32'h0000_010A);
        wr(6'd23, {28'h0, ~epar(pat(7))});
        wr(6'd7, 32'hC3A5_0F81);
        rd(6'd7);  chk("R3 rewrite clears fault", {31'b0, last_err}, 32'h0);
        rd(6'd23); chk("R3 regenerated parity", last_rd, {28'h0, epar(32'hC3A5_0F81)});

        // R11: request held through the ack cycle
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'd9; bus_wdata = 32'hAAAA_5555;
        @(negedge clk);
        bus_wdata = 32'h1111_2222;
        @(negedge clk);
        bus_req = 1'b0;
        rd(6'd9); chk("R11 held request ignored", last_rd, 32'hAAAA_5555);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule